// File: doc/BRIEF.md
# Configurable External Bus Cycle Controller

This block runs memory cycles for one address area. A CPU-side request carries an address, a read/write flag, a byte/word size and write data. The block first decides where the address belongs. When the on-chip RAM enable is set, a fixed address window is served internally. The upper part of that window is a small internal RAM. The lower part is reserved space. Every other address, and the whole window when the enable is clear, goes out on the external bus.

External cycles are shaped by per-area configuration inputs: a bus-width select, an access-length select, a two-bit wait-mode field and a two-bit wait count. A cycle lasts two or three states, plus up to three program wait states. A word access on an 8-bit bus is split into two byte cycles that run back to back. The configuration is sampled when a request is accepted.

The controller handles one request at a time. It signals readiness while idle and pulses `done` with the read data when the access completes.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: `cfg_narrow`=0 selects a 16-bit data bus. `cfg_narrow`=1 selects an 8-bit bus that carries data on `bus_dout[7:0]`/`bus_din[7:0]` with `bus_be`=01. On either width, data written is read back consistently.
- R2: `cfg_long`=0 gives 2 states per byte cycle with no wait states, whatever `cfg_wmode` and `cfg_wcnt` hold.
- R3: `cfg_long`=1 gives 3 states plus `cfg_wcnt` program waits (00→0, 01→1, 10→2, 11→3) per byte cycle, i.e. 3 to 6 states.
- R4: With `cfg_long`=1 and `cfg_wmode`=01, waits are suppressed and every byte cycle lasts exactly 3 states. Any other `cfg_wmode` value uses `cfg_wcnt`.
- R5: A word access on the 8-bit bus runs as two back-to-back byte cycles. The upper byte (`req_wdata[15:8]`) goes to the even address first, then the lower byte goes to the odd address. The total length is twice the single-cycle length.
- R6: Read timing and data lanes:
  - `bus_rd_n` is high in the first state and low from the second state to the end of the cycle.
  - Read data is captured in the last state.
  - A byte read returns its value in `rdata[7:0]` with the upper byte zero.
  - On the 16-bit bus, the even byte is on lane [15:8] and the odd byte on lane [7:0].
- R7: Write timing and lanes:
  - `bus_wr_n` is high in the first state and low from the second state to the end of the cycle.
  - `bus_doe` is high over the same states.
  - `bus_be` bit 1 enables lane [15:8] and bit 0 enables lane [7:0].
  - A byte write leaves the other byte of the pair unchanged.
  - `bus_rd_n` and `bus_wr_n` are never low together.
- R8: Handshake:
  - `done` is high for exactly one clock, the clock after the last state.
  - `req_ready` is high only while idle.
  - A request raised while busy is ignored and starts no bus cycle.
  - For an external access of N total states, `done` is visible N+1 clocks after the accepting edge.
- R9: Configuration changed during a cycle does not alter the cycle in progress. The next request uses the new values.
- R10: With `ram_en`=1, an address in the RAM part of the window is served by internal RAM with no bus cycle. `done` follows 2 clocks after acceptance. Word and byte reads and writes behave as on the 16-bit bus.
- R11: With `ram_en`=1, an address in the reserved part of the window reads as zero. A write there has no effect, and no bus cycle is run.
- R12: With `ram_en`=0, window addresses run an external bus cycle and leave the internal RAM unchanged.
- R13: After reset:
  - `bus_cyc`=0, `bus_rd_n`=1, `bus_wr_n`=1 and `bus_doe`=0.
  - `done`=0.
  - `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | Bus width: 0 = 16 bit, 1 = 8 bit |
| cfg_long | input | 1 | Access length: 0 = 2 states, 1 = 3 states |
| cfg_wmode | input | 2 | Wait mode; 01 suppresses waits |
| cfg_wcnt | input | 2 | Program wait count for 3-state cycles |
| ram_en | input | 1 | Serve the internal window when 1 |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle, request accepted this cycle |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with done |
| bus_cyc | output | 1 | External cycle in progress |
| bus_addr | output | AW | External address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_be | output | 2 | Lane enables: bit1 = [15:8], bit0 = [7:0] |
| bus_doe | output | 1 | Write data drive enable |
| bus_dout | output | 16 | Write data |
| bus_din | input | 16 | Read data |

## Verification
Two things can fall in the same cycle: a new request arriving and an external cycle still counting its states. The bench provokes this by raising `req_valid` with a different address in the middle of a six-state read. It then requires three things: the latency of the original read is unchanged, `req_ready` is never seen high while `bus_cyc` is, and no further bus cycle follows `done`. A second overlap is provoked by changing the configuration inputs one clock into a long cycle. That case is judged by counting the cycle's states against the length sampled at acceptance.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int DW = 16;
  localparam int BW = 8;

  // Number of states in one byte cycle: 2, or 3 plus program waits.
  function automatic logic [2:0] cyc_states(input logic long_acc, input logic [1:0] wmode,
                                            input logic [1:0] wcnt);
    if (!long_acc) return 3'd2;
    if (wmode == 2'b01) return 3'd3;
    return 3'd3 + {1'b0, wcnt};
  endfunction

  function automatic logic [1:0] lane_be(input logic narrow, input logic word, input logic a0);
    if (narrow) return 2'b01;
    if (word) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [DW-1:0] lane_dout(input logic narrow, input logic word, input logic a0,
                                              input logic [BW-1:0] b, input logic [DW-1:0] wd);
    if (narrow) return {{BW{1'b0}}, b};
    if (word) return wd;
    return a0 ? {{BW{1'b0}}, b} : {b, {BW{1'b0}}};
  endfunction
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int AW        = 16,
  parameter int WIN_BASE  = 'hF000,
  parameter int WIN_BYTES = 'h0800,
  parameter int RAM_BYTES = 512,
  parameter int IW        = $clog2(RAM_BYTES / 2)
) (
  input  logic [AW-1:0] addr,
  input  logic          ram_en,
  output logic          is_int,
  output logic          is_rsv,
  output logic [IW-1:0] idx
);
  localparam logic [AW:0] WLO = (AW+1)'(WIN_BASE);
  localparam logic [AW:0] WHI = (AW+1)'(WIN_BASE + WIN_BYTES);
  localparam logic [AW:0] RLO = (AW+1)'(WIN_BASE + WIN_BYTES - RAM_BYTES);

  logic [AW:0] a_ext;
  logic [AW:0] off;

  always_comb begin
    a_ext  = {1'b0, addr};
    off    = a_ext - RLO;
    is_int = ram_en && (a_ext >= WLO) && (a_ext < WHI);
    is_rsv = a_ext < RLO;
    idx    = off[IW:1];
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          narrow,
  input  logic          long_acc,
  input  logic [1:0]    wmode,
  input  logic [1:0]    wcnt,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic          word,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          cyc,
  output logic [AW-1:0] baddr,
  output logic          rd_n,
  output logic          wr_n,
  output logic [1:0]    be,
  output logic          doe,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] din
);
  logic          l_narrow, l_write, l_word, l_split, l_second;
  logic [2:0]    l_nst, st;
  logic [DW-1:0] l_wdata;
  logic [AW-1:0] a_eff;
  logic [BW-1:0] b_in, b_out0;

  always_comb begin
    a_eff  = word ? {addr[AW-1:1], 1'b0} : addr;
    b_out0 = (narrow && word) ? wdata[DW-1:BW] : wdata[BW-1:0];
    b_in   = (l_narrow || baddr[0]) ? din[BW-1:0] : din[DW-1:BW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; rdata <= '0; cyc <= 1'b0; baddr <= '0;
      rd_n <= 1'b1; wr_n <= 1'b1; be <= 2'b00; doe <= 1'b0; dout <= '0;
      l_narrow <= 1'b0; l_write <= 1'b0; l_word <= 1'b0; l_split <= 1'b0;
      l_second <= 1'b0; l_nst <= 3'd3; st <= 3'd0; l_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          l_narrow <= narrow;
          l_write  <= write;
          l_word   <= word;
          l_split  <= narrow && word;
          l_second <= 1'b0;
          l_nst    <= cyc_states(long_acc, wmode, wcnt);
          l_wdata  <= wdata;
          st       <= 3'd1;
          cyc      <= 1'b1;
          baddr    <= a_eff;
          rd_n     <= 1'b1;
          wr_n     <= 1'b1;
          doe      <= 1'b0;
          be       <= lane_be(narrow, word, a_eff[0]);
          dout     <= lane_dout(narrow, word, a_eff[0], b_out0, wdata);
        end
      end else if (st != l_nst) begin
        st   <= st + 3'd1;
        rd_n <= l_write;
        wr_n <= !l_write;
        doe  <= l_write;
      end else begin
        if (l_split && !l_second) rdata[DW-1:BW] <= b_in;
        else if (l_split) rdata[BW-1:0] <= b_in;
        else if (!l_narrow && l_word) rdata <= din;
        else rdata <= {{BW{1'b0}}, b_in};
        rd_n <= 1'b1;
        wr_n <= 1'b1;
        doe  <= 1'b0;
        if (l_split && !l_second) begin
          l_second <= 1'b1;
          st       <= 3'd1;
          baddr    <= baddr | AW'(1);
          dout     <= {{BW{1'b0}}, l_wdata[BW-1:0]};
        end else begin
          busy <= 1'b0;
          cyc  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbus_iram.sv
module xbus_iram
  import xbus_pkg::*;
#(
  parameter int RAM_BYTES = 512,
  parameter int IW        = $clog2(RAM_BYTES / 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rsv,
  input  logic [IW-1:0] idx,
  input  logic          lane,
  input  logic          word,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = RAM_BYTES / 2;

  logic [BW-1:0] m_hi [WORDS];
  logic [BW-1:0] m_lo [WORDS];
  logic [BW-1:0] q_hi, q_lo;
  logic [IW-1:0] l_idx;
  logic          l_rsv, l_lane, l_word, l_write;
  logic [DW-1:0] l_wdata;
  logic          we_hi, we_lo;

  always_comb begin
    we_hi = busy && l_write && !l_rsv && (l_word || !l_lane);
    we_lo = busy && l_write && !l_rsv && (l_word || l_lane);
  end

  always_ff @(posedge clk) begin
    if (we_hi) m_hi[l_idx] <= l_word ? l_wdata[DW-1:BW] : l_wdata[BW-1:0];
    if (busy) q_hi <= m_hi[l_idx];
  end

  always_ff @(posedge clk) begin
    if (we_lo) m_lo[l_idx] <= l_wdata[BW-1:0];
    if (busy) q_lo <= m_lo[l_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; l_idx <= '0; l_rsv <= 1'b0;
      l_lane <= 1'b0; l_word <= 1'b0; l_write <= 1'b0; l_wdata <= '0;
    end else begin
      done <= busy;
      if (busy) busy <= 1'b0;
      else if (start) begin
        busy    <= 1'b1;
        l_idx   <= idx;
        l_rsv   <= rsv;
        l_lane  <= lane;
        l_word  <= word;
        l_write <= write;
        l_wdata <= wdata;
      end
    end
  end

  always_comb begin
    if (l_rsv) rdata = '0;
    else if (l_word) rdata = {q_hi, q_lo};
    else rdata = {{BW{1'b0}}, l_lane ? q_lo : q_hi};
  end
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int WIN_BASE  = 'hF000,
  parameter int WIN_BYTES = 'h0800,
  parameter int RAM_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_narrow,
  input  logic          cfg_long,
  input  logic [1:0]    cfg_wmode,
  input  logic [1:0]    cfg_wcnt,
  input  logic          ram_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_cyc,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [1:0]    bus_be,
  output logic          bus_doe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);
  localparam int IW = $clog2(RAM_BYTES / 2);

  logic          is_int, is_rsv, accept;
  logic [IW-1:0] idx;
  logic          seq_busy, seq_done, ram_busy, ram_done;
  logic [DW-1:0] seq_rdata, ram_rdata;

  xbus_decode #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
                .RAM_BYTES(RAM_BYTES), .IW(IW)) u_dec (
    .addr(req_addr), .ram_en(ram_en), .is_int(is_int), .is_rsv(is_rsv), .idx(idx));

  always_comb begin
    req_ready = !seq_busy && !ram_busy;
    accept    = req_valid && req_ready;
  end

  xbus_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(accept && !is_int), .narrow(cfg_narrow),
    .long_acc(cfg_long), .wmode(cfg_wmode), .wcnt(cfg_wcnt), .addr(req_addr),
    .write(req_write), .word(req_word), .wdata(req_wdata), .busy(seq_busy),
    .done(seq_done), .rdata(seq_rdata), .cyc(bus_cyc), .baddr(bus_addr),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .be(bus_be), .doe(bus_doe),
    .dout(bus_dout), .din(bus_din));

  xbus_iram #(.RAM_BYTES(RAM_BYTES), .IW(IW)) u_ram (
    .clk(clk), .rst(rst), .start(accept && is_int), .rsv(is_rsv), .idx(idx),
    .lane(req_addr[0]), .word(req_word), .write(req_write), .wdata(req_wdata),
    .busy(ram_busy), .done(ram_done), .rdata(ram_rdata));

  always_comb begin
    done  = seq_done || ram_done;
    rdata = ram_done ? ram_rdata : seq_rdata;
  end
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
  parameter int AW        = 16,
  parameter int WIN_BASE  = 'hF000,
  parameter int WIN_BYTES = 'h0800
) (
  input logic          clk,
  input logic          rst,
  input logic          ram_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          done,
  input logic          bus_cyc,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_doe
);
  localparam logic [AW:0] WLO = (AW+1)'(WIN_BASE);
  localparam logic [AW:0] WHI = (AW+1)'(WIN_BASE + WIN_BYTES);

  logic take_int;
  assign take_int = req_valid && req_ready && ram_en &&
                    ({1'b0, req_addr} >= WLO) && ({1'b0, req_addr} < WHI);

  a_r6_rd_inside_cycle: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> bus_cyc);
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));
  a_r7_first_state_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cyc) |-> (bus_rd_n && bus_wr_n && !bus_doe));
  a_r7_drive_only_writing: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (bus_cyc && !bus_wr_n));
  a_r8_done_one_clock: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_not_ready_busy: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> !req_ready);
  a_r10_internal_no_bus: assert property (@(posedge clk) disable iff (rst)
    take_int |=> !bus_cyc);
endmodule

bind xbus_cycle_ctrl xbus_chk #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk(clk), .rst(rst), .ram_en(ram_en), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .done(done), .bus_cyc(bus_cyc), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_doe(bus_doe));

// File: tb/xbus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_cycle_ctrl_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_narrow = 0, cfg_long = 1, ram_en = 0;
  logic [1:0] cfg_wmode = 0, cfg_wcnt = 0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic req_ready, done, bus_cyc, bus_rd_n, bus_wr_n, bus_doe;
  logic [15:0] req_addr = 0, req_wdata = 0, rdata, bus_addr, bus_dout, bus_din;
  logic [1:0] bus_be;

  int n_cmp = 0, n_bad = 0, ready_bad = 0;
  logic done_after;
  logic model_narrow = 0;
  logic [7:0] mem [256];

  always #2 clk = ~clk;

  xbus_cycle_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .cfg_long(cfg_long),
    .cfg_wmode(cfg_wmode), .cfg_wcnt(cfg_wcnt), .ram_en(ram_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_be(bus_be),
    .bus_doe(bus_doe), .bus_dout(bus_dout), .bus_din(bus_din));

  // external memory model
  always_comb begin
    if (model_narrow) bus_din = {8'h00, mem[bus_addr[7:0]]};
    else bus_din = {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};
  end

  always @(negedge clk) begin
    if (!bus_wr_n && bus_doe) begin
      if (model_narrow) begin
        if (bus_be[0]) mem[bus_addr[7:0]] = bus_dout[7:0];
      end else begin
        if (bus_be[1]) mem[{bus_addr[7:1], 1'b0}] = bus_dout[15:8];
        if (bus_be[0]) mem[{bus_addr[7:1], 1'b1}] = bus_dout[7:0];
      end
    end
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // mode 1: raise a stray request at the 2nd busy sample; mode 2: change config after 1st
  task automatic xact(input logic [15:0] a, input logic wr, input logic wd, input logic [15:0] dat,
                      input int mode, output logic [15:0] rd, output int ncyc, output int nrdl,
                      output int nwrl, output int lat);
    @(negedge clk);
    model_narrow = cfg_narrow;
    req_addr = a; req_write = wr; req_word = wd; req_wdata = dat; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    ncyc = 0; nrdl = 0; nwrl = 0; lat = 0; rd = 16'hxxxx;
    while (1) begin
      lat++;
      if (bus_cyc) ncyc++;
      if (!bus_rd_n) nrdl++;
      if (!bus_wr_n) nwrl++;
      if (bus_cyc && req_ready) ready_bad++;
      if (done) begin rd = rdata; break; end
      req_valid = 0;
      if (mode == 1 && lat == 2) begin req_valid = 1; req_addr = a ^ 16'h0040; end
      if (mode == 2 && lat == 1) begin cfg_long = 0; cfg_wcnt = 0; end
      if (lat > 200) begin chk("R8 done timeout", 0, 1); break; end
      @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    done_after = done;
  endtask

  localparam logic [30:0] VEC [10] = '{
    {1'b0, 1'b0, 2'd0, 2'd3, 1'b1, 8'h20, 16'h1234},
    {1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 8'h22, 16'hABCD},
    {1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 8'h25, 16'h0077},
    {1'b0, 1'b1, 2'd2, 2'd2, 1'b0, 8'h26, 16'h0055},
    {1'b0, 1'b1, 2'd3, 2'd3, 1'b1, 8'h28, 16'hBEEF},
    {1'b0, 1'b1, 2'd1, 2'd3, 1'b1, 8'h2A, 16'h0F0F},
    {1'b1, 1'b0, 2'd1, 2'd0, 1'b1, 8'h30, 16'hA1B2},
    {1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 8'h32, 16'hC3D4},
    {1'b1, 1'b1, 2'd1, 2'd3, 1'b0, 8'h35, 16'h0099},
    {1'b1, 1'b0, 2'd3, 2'd2, 1'b0, 8'h36, 16'h0042}
  };

  logic finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk("watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int nc, nr, nw, lt;
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk("R13 reset outputs", {bus_cyc, bus_rd_n, bus_wr_n, bus_doe, done, req_ready},
        6'b011001);

    for (int i = 0; i < 10; i++) begin
      logic nar, lng, wd;
      logic [1:0] wm, wc;
      logic [7:0] ad;
      logic [15:0] dat;
      int n, nb;
      string tg;
      {nar, lng, wm, wc, wd, ad, dat} = VEC[i];
      cfg_narrow = nar; cfg_long = lng; cfg_wmode = wm; cfg_wcnt = wc; ram_en = 0;
      n = !lng ? 2 : (wm == 2'b01 ? 3 : 3 + int'(wc));
      nb = (nar && wd) ? 2 : 1;
      tg = !lng ? "R2 length" : (wm == 2'b01 ? "R4 length" : "R3 length");
      xact({8'h00, ad}, 1'b1, wd, dat, 0, rd, nc, nr, nw, lt);
      chk(tg, nc, n * nb);
      chk("R7 write strobe states", nw, (n - 1) * nb);
      chk("R7 no read strobe on write", nr, 0);
      xact({8'h00, ad}, 1'b0, wd, dat, 0, rd, nc, nr, nw, lt);
      chk("R6 read data", rd, wd ? dat : {8'h00, dat[7:0]});
      chk("R6 read strobe states", nr, (n - 1) * nb);
      chk(tg, nc, n * nb);
      chk("R8 latency", lt, n * nb + 1);
      chk("R8 done single", done_after, 0);
      if (nar && wd) begin
        chk("R5 even byte first", mem[ad], dat[15:8]);
        chk("R5 odd byte second", mem[ad + 8'd1], dat[7:0]);
      end
      if (!wd) chk(nar ? "R1 narrow byte lane" : "R7 byte enable",
                   mem[ad ^ 8'h01], init_val(int'(ad ^ 8'h01)));
    end

    // R1 cross-width: narrow-written word read on the 16-bit bus
    cfg_narrow = 0; cfg_long = 1; cfg_wmode = 0; cfg_wcnt = 0;
    xact(16'h0030, 1'b0, 1'b1, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R1 wide read of narrow write", rd, 16'hA1B2);
    xact(16'h0024, 1'b0, 1'b0, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R6 even byte upper lane", rd, {8'h00, init_val(16'h24)});

    // R8 stray request while busy
    cfg_wcnt = 3; ready_bad = 0;
    xact(16'h0040, 1'b0, 1'b1, 16'h0, 1, rd, nc, nr, nw, lt);
    chk("R8 latency with stray request", lt, 7);
    chk("R8 ready low while busy", ready_bad, 0);
    nc = 0;
    repeat (8) begin @(negedge clk); if (bus_cyc) nc++; end
    chk("R8 stray request ignored", nc, 0);

    // R9 config change mid-cycle
    cfg_long = 1; cfg_wmode = 0; cfg_wcnt = 3;
    xact(16'h0020, 1'b0, 1'b1, 16'h0, 2, rd, nc, nr, nw, lt);
    chk("R9 cycle keeps sampled length", nc, 6);
    chk("R9 data", rd, 16'h1234);
    xact(16'h0020, 1'b0, 1'b1, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R9 next cycle uses new config", nc, 2);

    // R10 internal RAM
    ram_en = 1; cfg_long = 1; cfg_wcnt = 0;
    xact(16'hF600, 1'b1, 1'b1, 16'h5566, 0, rd, nc, nr, nw, lt);
    chk("R10 no bus cycle", nc, 0);
    chk("R10 latency", lt, 2);
    xact(16'hF600, 1'b0, 1'b1, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R10 word read", rd, 16'h5566);
    xact(16'hF601, 1'b0, 1'b0, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R10 odd byte read", rd, 16'h0066);
    xact(16'hF600, 1'b1, 1'b0, 16'h0099, 0, rd, nc, nr, nw, lt);
    xact(16'hF600, 1'b0, 1'b1, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R10 even byte write", rd, 16'h9966);

    // R11 reserved part of the window
    xact(16'hF100, 1'b1, 1'b1, 16'h1111, 0, rd, nc, nr, nw, lt);
    chk("R11 no bus cycle", nc, 0);
    xact(16'hF100, 1'b0, 1'b1, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R11 reads zero", rd, 16'h0000);

    // R12 window routed outside when disabled
    ram_en = 0;
    xact(16'hF600, 1'b1, 1'b1, 16'h7788, 0, rd, nc, nr, nw, lt);
    chk("R12 bus cycle runs", nc, 3);
    chk("R12 external memory written", mem[8'h00], 8'h77);
    ram_en = 1;
    xact(16'hF600, 1'b0, 1'b1, 16'h0, 0, rd, nc, nr, nw, lt);
    chk("R12 internal RAM untouched", rd, 16'h9966);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule